// File: doc/BRIEF.md
# Vector Double-to-Single Round-to-Odd Converter

The block narrows a vector of 64-bit IEEE-754 double-precision values to 32-bit single precision. It always rounds to odd. The mantissa is cut to 23 bits, and its lowest bit is forced to 1 whenever any discarded bit was nonzero. Because the result still records that it was inexact, a later narrowing to half precision gives the same answer as a single correctly rounded conversion.

Each 64-bit lane has one predicate bit. An active lane writes its single-precision result into bits [31:0] of its slot, writes zero into bits [63:32], and reports four exception flags. An inactive lane passes its previous destination contents through unchanged and reports no flags.

A transfer into the block happens on a clock edge where `in_valid` and `in_ready` are both high. The result appears one cycle later on `out_valid`, held in a single output register. While `out_valid` is high and `out_ready` is low, the output is stalled: it holds still and `in_ready` is low. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A producer may raise `in_valid` at any time and must hold its data until the transfer completes.

Top module: `dp2sp_rto_conv`

## Requirements
- R1: For a lane whose predicate bit is 1, out_vec bits [64i+31:64i] carry the single-precision result and bits [64i+63:64i+32] are zero.
- R2: For a lane whose predicate bit is 0, the 64-bit slot of out_vec equals that lane's in_dst_old slot, and its four flags are zero.
- R3: For a biased double exponent in the range 897 to 1150, the result takes the sign, the exponent minus 896, and fraction bits [51:29]. Bit 0 is forced to 1, and inexact is raised, when any of fraction bits [28:0] is set.
- R4: For a biased exponent from 1151 to 2046, the result is 0x7F7FFFFF with the input sign, and overflow and inexact are raised.
- R5: Zeros and infinities convert exactly to signed zero and signed infinity (0x7F800000 with the sign bit), with no flags.
- R6: A NaN input gives exponent 0xFF, fraction bit 22 set, and fraction bits [21:0] taken from double fraction bits [50:29], with the sign kept. Invalid is raised only when double fraction bit 51 is 0 (signaling).
- R7: For a biased exponent from 1 to 896, the significand with its hidden bit is shifted right by 926 minus the exponent and rounded to odd into a subnormal result. Underflow and inexact are both raised exactly when a shifted-out bit was nonzero.
- R8: A double subnormal input (exponent 0, fraction nonzero) gives the signed smallest subnormal (magnitude 0x00000001) and raises underflow and inexact.
- R9: The flags of lane i sit at out_flags[4i+3:4i] in the order {invalid, overflow, underflow, inexact}.
- R10: A transfer on an edge with in_valid and in_ready both high makes out_valid high after that edge. in_ready is high when out_valid is low.
- R11: While out_valid is high and out_ready is low, out_vec and out_flags stay unchanged, out_valid stays high, and in_ready is low.
- R12: During and right after reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat is valid |
| in_ready | output | 1 | Block can take an input beat |
| in_src | input | 64*LANES | Double-precision source elements |
| in_dst_old | input | 64*LANES | Previous destination contents |
| in_pred | input | LANES | Per-lane predicate, 1 = active |
| out_valid | output | 1 | Output beat is valid |
| out_ready | input | 1 | Consumer takes the output beat |
| out_vec | output | 64*LANES | Updated destination vector |
| out_flags | output | 4*LANES | Per-lane {invalid, overflow, underflow, inexact} |

## Verification
The bench builds the block with LANES set to 3. An odd lane count catches slicing errors at the top lane that an even count can hide. It also lets each beat mix active and inactive lanes. Random exponents are steered into the bands around the single-precision normal floor (860 to 900) and the overflow edge (1140 to 1160), so the shift widths and both boundaries are covered. Output stalls of varying length exercise the hold rules while a competing beat waits at the input.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
  localparam int DP_W   = 64;
  localparam int SP_W   = 32;
  localparam int FLAG_W = 4;

  typedef struct packed {
    logic nv;  // invalid
    logic of;  // overflow
    logic uf;  // underflow
    logic nx;  // inexact
  } fcvt_flags_t;
endpackage

// File: rtl/rto_lane_conv.sv
module rto_lane_conv
  import fcvt_pkg::*;
(
  input  logic [DP_W-1:0] src,
  output logic [SP_W-1:0] res,
  output fcvt_flags_t     flg
);
  localparam logic [10:0] EXP_MAX   = 11'h7FF;
  localparam logic [10:0] EXP_OVF   = 11'd1151;
  localparam logic [10:0] EXP_NORM  = 11'd897;
  localparam logic [10:0] EXP_DEEP  = 11'd863;
  localparam logic [10:0] REBIAS    = 11'd896;
  localparam logic [10:0] SUB_SHIFT = 11'd926;

  logic        sgn;
  logic [10:0] ex;
  logic [51:0] fr;
  logic [52:0] sig;
  logic [5:0]  sh;
  logic [22:0] shifted;
  logic        lost;
  logic        sticky_n;

  always_comb begin
    sgn      = src[63];
    ex       = src[62:52];
    fr       = src[51:0];
    sig      = {1'b1, fr};
    sh       = (ex < EXP_DEEP) ? 6'd63 : 6'(SUB_SHIFT - ex);
    shifted  = 23'(sig >> sh);
    lost     = |(sig & ~({53{1'b1}} << sh));
    sticky_n = |fr[28:0];
    res      = '0;
    flg      = '0;
    if (ex == EXP_MAX) begin
      if (fr == '0) begin
        res = {sgn, 8'hFF, 23'h0};
      end else begin
        res    = {sgn, 8'hFF, 1'b1, fr[50:29]};
        flg.nv = ~fr[51];
      end
    end else if (ex == '0) begin
      if (fr == '0) begin
        res = {sgn, 31'h0};
      end else begin
        res    = {sgn, 30'h0, 1'b1};
        flg.uf = 1'b1;
        flg.nx = 1'b1;
      end
    end else if (ex >= EXP_OVF) begin
      res    = {sgn, 8'hFE, {23{1'b1}}};
      flg.of = 1'b1;
      flg.nx = 1'b1;
    end else if (ex >= EXP_NORM) begin
      res    = {sgn, 8'(ex - REBIAS), fr[51:30], fr[29] | sticky_n};
      flg.nx = sticky_n;
    end else begin
      res    = {sgn, 8'h00, shifted[22:1], shifted[0] | lost};
      flg.uf = lost;
      flg.nx = lost;
    end
  end
endmodule

// File: rtl/rto_lane_slot.sv
module rto_lane_slot
  import fcvt_pkg::*;
(
  input  logic [DP_W-1:0] src,
  input  logic [DP_W-1:0] old,
  input  logic            pred,
  output logic [DP_W-1:0] slot,
  output fcvt_flags_t     flags
);
  logic [SP_W-1:0] conv_res;
  fcvt_flags_t     conv_flg;

  rto_lane_conv u_conv (
    .src (src),
    .res (conv_res),
    .flg (conv_flg)
  );

  always_comb begin
    if (pred) begin
      slot  = {{(DP_W-SP_W){1'b0}}, conv_res};
      flags = conv_flg;
    end else begin
      slot  = old;
      flags = '0;
    end
  end
endmodule

// File: rtl/rto_out_stage.sv
module rto_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/dp2sp_rto_conv.sv
module dp2sp_rto_conv
  import fcvt_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [LANES*DP_W-1:0] in_src,
  input  logic [LANES*DP_W-1:0] in_dst_old,
  input  logic [LANES-1:0]      in_pred,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [LANES*DP_W-1:0] out_vec,
  output logic [LANES*FLAG_W-1:0] out_flags
);
  localparam int VEC_W = LANES * DP_W;
  localparam int FLG_W = LANES * FLAG_W;
  localparam int PKT_W = VEC_W + FLG_W;

  logic [VEC_W-1:0] nxt_vec;
  logic [FLG_W-1:0] nxt_flags;
  logic [PKT_W-1:0] reg_pkt;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    fcvt_flags_t lane_flg;
    rto_lane_slot u_slot (
      .src   (in_src[i*DP_W +: DP_W]),
      .old   (in_dst_old[i*DP_W +: DP_W]),
      .pred  (in_pred[i]),
      .slot  (nxt_vec[i*DP_W +: DP_W]),
      .flags (lane_flg)
    );
    assign nxt_flags[i*FLAG_W +: FLAG_W] = lane_flg;
  end

  rto_out_stage #(.W(PKT_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   ({nxt_flags, nxt_vec}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (reg_pkt)
  );

  assign out_vec   = reg_pkt[VEC_W-1:0];
  assign out_flags = reg_pkt[PKT_W-1:VEC_W];
endmodule

// File: rtl/rto_cvt_chk.sv
module rto_cvt_chk #(
  parameter int LANES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [LANES*64-1:0]  in_dst_old,
  input logic [LANES-1:0]     in_pred,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [LANES*64-1:0]  out_vec,
  input logic [LANES*4-1:0]   out_flags
);
  // R10
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vec) && $stable(out_flags)));

  // R11
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
    // R1
    high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_pred[i]) |=> (out_vec[i*64+32 +: 32] == 32'h0));

    // R2
    inactive_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !in_pred[i]) |=>
        (out_vec[i*64 +: 64] == $past(in_dst_old[i*64 +: 64]) && out_flags[i*4 +: 4] == 4'h0));

    // R4
    ovf_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_flags[i*4+2]) |->
        (out_flags[i*4] && out_vec[i*64 +: 31] == 31'h7F7FFFFF));

    // R7
    uf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_flags[i*4+1]) |-> out_flags[i*4]);
  end
endmodule

bind dp2sp_rto_conv rto_cvt_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_dst_old (in_dst_old),
  .in_pred    (in_pred),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_vec    (out_vec),
  .out_flags  (out_flags)
);

// File: tb/dp2sp_rto_conv_tb.sv
module dp2sp_rto_conv_tb;
  localparam int LANES = 3;
  localparam int VW    = LANES * 64;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic            in_ready;
  logic [VW-1:0]   in_src;
  logic [VW-1:0]   in_dst_old;
  logic [LANES-1:0] in_pred;
  logic            out_valid;
  logic            out_ready;
  logic [VW-1:0]   out_vec;
  logic [LANES*4-1:0] out_flags;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  dp2sp_rto_conv #(.LANES(LANES)) u_dut (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (in_ready),
    .in_src (in_src), .in_dst_old (in_dst_old), .in_pred (in_pred),
    .out_valid (out_valid), .out_ready (out_ready),
    .out_vec (out_vec), .out_flags (out_flags)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference: {flags(nv,of,uf,nx), result}
  function automatic logic [35:0] ref_cvt(input logic [63:0] d);
    int          e;
    logic [63:0] sv;
    logic        st;
    logic [31:0] r;
    logic [3:0]  fl;
    e  = int'(d[62:52]);
    st = 1'b0;
    fl = 4'h0;
    if (e == 2047) begin
      if (d[51:0] == 0) r = {d[63], 31'h7F800000};
      else begin
        r  = {d[63], 9'h1FF, d[50:29]};
        fl = {~d[51], 3'b000};
      end
    end else if (e == 0) begin
      if (d[51:0] == 0) r = {d[63], 31'h0};
      else begin r = {d[63], 31'h1}; fl = 4'b0011; end
    end else if (e - 896 >= 255) begin
      r = {d[63], 31'h7F7FFFFF}; fl = 4'b0101;
    end else if (e - 896 >= 1) begin
      st = |d[28:0];
      r  = {d[63], 8'(e - 896), d[51:29]};
      r[0] = r[0] | st;
      fl = {3'b000, st};
    end else begin
      sv = {11'h0, 1'b1, d[51:0]};
      for (int k = 0; k < 926 - e; k++) begin
        st = st | sv[0];
        sv = sv >> 1;
      end
      r  = {d[63], 8'h00, sv[22:0]};
      r[0] = r[0] | st;
      fl = {2'b00, st, st};
    end
    return {fl, r};
  endfunction

  function automatic string cls(input logic [63:0] d);
    int e;
    e = int'(d[62:52]);
    if (e == 2047) return (d[51:0] == 0) ? "R5" : "R6";
    if (e == 0)    return (d[51:0] == 0) ? "R5" : "R8";
    if (e >= 1151) return "R4";
    if (e >= 897)  return "R3";
    return "R7";
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  function automatic logic [63:0] rnd_val();
    logic [63:0] v;
    int sel;
    v   = rnd64();
    sel = int'($urandom() % 6);
    case (sel)
      0: v[62:52] = 11'(860 + $urandom() % 41);
      1: v[62:52] = 11'(1140 + $urandom() % 21);
      2: v[62:52] = ($urandom() % 2) ? 11'h7FF : 11'h000;
      3: v[62:52] = 11'(1 + $urandom() % 40);
      default: ;
    endcase
    return v;
  endfunction

  task automatic run_txn(input logic [VW-1:0] src, input logic [VW-1:0] old,
                         input logic [LANES-1:0] pred, input int stall);
    logic [VW-1:0]      held_vec;
    logic [LANES*4-1:0] held_flg;
    logic [35:0]        rv;
    @(negedge clk);
    in_src = src; in_dst_old = old; in_pred = pred; in_valid = 1'b1;
    out_ready = 1'b0;
    chk("R10 in_ready when empty", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 out_valid after accept", 64'(out_valid), 64'd1);
    for (int i = 0; i < LANES; i++) begin
      rv = ref_cvt(src[i*64 +: 64]);
      if (pred[i]) begin
        chk({cls(src[i*64 +: 64]), " R1 lane result"}, out_vec[i*64 +: 64], {32'h0, rv[31:0]});
        chk("R9 lane flags", 64'(out_flags[i*4 +: 4]), 64'(rv[35:32]));
      end else begin
        chk("R2 inactive slot", out_vec[i*64 +: 64], old[i*64 +: 64]);
        chk("R2 inactive flags", 64'(out_flags[i*4 +: 4]), 64'd0);
      end
    end
    held_vec = out_vec;
    held_flg = out_flags;
    for (int s = 0; s < stall; s++) begin
      in_valid = 1'b1;
      in_src = ~src; in_dst_old = ~old; in_pred = ~pred;
      @(negedge clk);
      chk("R11 in_ready low while stalled", 64'(in_ready), 64'd0);
      chk("R11 out_valid held", 64'(out_valid), 64'd1);
      chk("R11 vec held", 64'(out_vec == held_vec), 64'd1);
      chk("R11 flags held", 64'(out_flags == held_flg), 64'd1);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk("R10 drained", 64'(out_valid), 64'd0);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] dv [12];
    logic [VW-1:0] s, o;
    void'($urandom(32'd4242));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_src = '0; in_dst_old = '0; in_pred = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 out_valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 out_valid after reset", 64'(out_valid), 64'd0);
    chk("R12 in_ready after reset", 64'(in_ready), 64'd1);

    dv[0]  = 64'h3FF0000000000000; // 1.0 exact
    dv[1]  = 64'h3FF0000000000001; // sticky forces LSB
    dv[2]  = 64'h8000000000000000; // -0
    dv[3]  = 64'hFFF0000000000000; // -inf
    dv[4]  = 64'h7FF0000000000001; // sNaN
    dv[5]  = 64'hFFF8000020000000; // qNaN with payload bit
    dv[6]  = 64'h47EFFFFFE0000000; // largest finite exact
    dv[7]  = 64'hC7F0000000000000; // first overflow exponent, negative
    dv[8]  = 64'h3800000000000000; // 2^-127 exact subnormal
    dv[9]  = 64'h3810000000000000; // 2^-126 smallest normal
    dv[10] = 64'h0000000000000001; // double subnormal
    dv[11] = 64'h0010000000000000; // deep tiny normal
    for (int t = 0; t < 4; t++) begin
      s = {dv[t*3+2], dv[t*3+1], dv[t*3]};
      o = {rnd64(), rnd64(), rnd64()};
      run_txn(s, o, 3'b111, t % 2);
    end
    s = {dv[1], dv[4], dv[7]};
    run_txn(s, {rnd64(), rnd64(), rnd64()}, 3'b010, 2);

    for (int t = 0; t < 80; t++) begin
      s = {rnd_val(), rnd_val(), rnd_val()};
      o = {rnd64(), rnd64(), rnd64()};
      run_txn(s, o, 3'($urandom()), int'($urandom() % 4));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule